// File: doc/BRIEF.md
# Control-Flow Label Allocator with Squash Tracking

This block hands out a small pool of labels to control-flow instructions as they are dispatched in an out-of-order core. Each label is entered into a program-order queue, and the queue slot it lands in is returned so that the instruction can carry it. The block keeps the most recently handed-out label as the current label. Ordinary dispatches are tagged with that label, so that any later squash can find them.

When a control-flow instruction resolves without a redirect, its label returns to the pool and its queue slot is marked dead. Dead slots at the oldest end of the queue drain away one per cycle. A resolution with a redirect does four things. It reports a squash mask with every live label from the resolved slot to the youngest. It returns those labels to the pool, cuts the queue back to the resolved position, and rewinds the current label. Dispatch of new control-flow instructions is held off while this recovery takes place.

Top module: `cf_label_tracker`

## Requirements
- R1: After reset all 8 labels are free, the queue is empty, `cur_valid` and `squash_valid` are 0, and a request is granted label 0 in slot 0.
- R2: A granted request receives the lowest-numbered free label, and that label is not handed out again until it is freed.
- R3: `alloc_grant` stays 0 while no label is free or while all 8 queue slots are occupied, including dead ones not yet drained.
- R4: Granted entries occupy consecutive queue slots modulo 8, and `alloc_slot` reports the slot used.
- R5: After a grant, `cur_valid` is 1 and `cur_label` equals the granted label from the next cycle on.
- R6: A non-redirect resolution of slot s frees the label held there, which can be granted from the next cycle. If that label is the current label, `cur_valid` drops to 0.
- R7: While the oldest occupied slot is dead, it is removed from the queue, one slot per cycle, which makes room for new grants.
- R8: A redirect at slot s raises `squash_valid` in the next cycle. In that cycle `squash_mask` has bit k set exactly for each live slot from s through the youngest that holds label k.
- R9: The labels in a squash mask are returned to the pool, and the next granted slot after a redirect at slot s is s.
- R10: After a redirect at slot s, `cur_label` is the label in slot s-1 if that slot is still occupied and live; otherwise `cur_valid` is 0.
- R11: A request made in the same cycle as a redirect is dropped, and no grant is made in the cycle after a redirect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | A control-flow instruction wants a label |
| alloc_grant | output | 1 | Label granted this cycle; dispatch stalls when 0 |
| alloc_label | output | 3 | Label granted |
| alloc_slot | output | 3 | Queue slot of the granted label |
| cur_valid | output | 1 | A current label exists |
| cur_label | output | 3 | Label to tag later dispatches with |
| res_valid | input | 1 | A control-flow instruction resolves |
| res_redirect | input | 1 | The resolution redirects fetch |
| res_slot | input | 3 | Queue slot of the resolving instruction |
| squash_valid | output | 1 | Squash report valid (cycle after a redirect) |
| squash_mask | output | 8 | One bit per label to squash |

## Verification
Two pairs of events are made to fall in the same cycle. The first pair is a grant and a resolution. The second is a request and a redirect, provoked both at hand-picked points and throughout a long random run. A directed sequence fills the queue, kills a slot in the middle, and drains a dead slot at the head. It then redirects while the queue has wrapped and a request is pending, and the exact mask, the rewound current label and the reused slot are checked. Each cycle the outputs are compared against a behavioural model of the queue and pool written from the requirements. A grant made alongside a redirect, or a mask that misses a wrapped slot, shows up as a miscompare.

// File: rtl/cf_label_pkg.sv
package cf_label_pkg;
  parameter int NUM_LBL = 8;
  localparam int LBL_W = $clog2(NUM_LBL);
endpackage

// File: rtl/cf_lowest_free.sv
module cf_lowest_free #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] free_vec,
  output logic         any_free,
  output logic [W-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) pick = W'(i);
    end
  end
  assign any_free = |free_vec;
endmodule

// File: rtl/cf_squash_span.sv
module cf_squash_span #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] slot_lbl,
  input  logic [N-1:0]        slot_live,
  input  logic [W-1:0]        head,
  input  logic [W:0]          count,
  input  logic [W-1:0]        from_slot,
  output logic [N-1:0]        in_span,
  output logic [N-1:0]        lbl_mask
);
  logic [W-1:0] from_off;
  assign from_off = from_slot - head;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] off;
    assign off = W'(g) - head;
    assign in_span[g] = (off >= from_off) && ({1'b0, off} < count) && slot_live[g];
  end

  always_comb begin
    lbl_mask = '0;
    for (int i = 0; i < N; i++) begin
      if (in_span[i]) lbl_mask[slot_lbl[i]] = 1'b1;
    end
  end
endmodule

// File: rtl/cf_label_tracker.sv
module cf_label_tracker
  import cf_label_pkg::*;
#(
  parameter int N = NUM_LBL,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc_req,
  output logic         alloc_grant,
  output logic [W-1:0] alloc_label,
  output logic [W-1:0] alloc_slot,
  output logic         cur_valid,
  output logic [W-1:0] cur_label,
  input  logic         res_valid,
  input  logic         res_redirect,
  input  logic [W-1:0] res_slot,
  output logic         squash_valid,
  output logic [N-1:0] squash_mask
);
  logic [N-1:0]        free_q, free_d;
  logic [N-1:0][W-1:0] lbl_q, lbl_d;
  logic [N-1:0]        live_q, live_d;
  logic [W-1:0]        head_q, head_d;
  logic [W:0]          cnt_q, cnt_d;
  logic                cur_v_q, cur_v_d;
  logic [W-1:0]        cur_q, cur_d;
  logic                sq_v_q, sq_v_d;
  logic [N-1:0]        sq_m_q, sq_m_d;

  logic         any_free, redir, keep, pop;
  logic [W-1:0] pick, tail, from_off, prev_slot;
  logic [N-1:0] span, mask;

  cf_lowest_free #(.N(N)) u_pick (
    .free_vec(free_q), .any_free(any_free), .pick(pick)
  );

  cf_squash_span #(.N(N)) u_span (
    .slot_lbl(lbl_q), .slot_live(live_q), .head(head_q), .count(cnt_q),
    .from_slot(res_slot), .in_span(span), .lbl_mask(mask)
  );

  assign redir     = res_valid & res_redirect;
  assign keep      = res_valid & ~res_redirect;
  assign pop       = (cnt_q != '0) & ~live_q[head_q];
  assign tail      = head_q + cnt_q[W-1:0];
  assign from_off  = res_slot - head_q;
  assign prev_slot = res_slot - 1'b1;

  assign alloc_grant = alloc_req & ~redir & ~sq_v_q & any_free & (cnt_q != (W+1)'(N));
  assign alloc_label = pick;
  assign alloc_slot  = tail;

  always_comb begin
    free_d  = free_q;
    lbl_d   = lbl_q;
    live_d  = live_q;
    cur_v_d = cur_v_q;
    cur_d   = cur_q;
    head_d  = head_q + W'(pop);
    sq_v_d  = redir;
    sq_m_d  = redir ? mask : '0;
    cnt_d   = cnt_q - (W+1)'(pop) + (W+1)'(alloc_grant);
    if (keep) begin
      free_d[lbl_q[res_slot]] = 1'b1;
      live_d[res_slot]        = 1'b0;
      if (cur_v_q && (cur_q == lbl_q[res_slot])) cur_v_d = 1'b0;
    end
    if (redir) begin
      free_d  = free_q | mask;
      live_d  = live_q & ~span;
      cnt_d   = {1'b0, from_off} - (W+1)'(pop);
      cur_v_d = (from_off != '0) && live_q[prev_slot];
      cur_d   = lbl_q[prev_slot];
    end
    if (alloc_grant) begin
      lbl_d[tail]  = pick;
      live_d[tail] = 1'b1;
      free_d[pick] = 1'b0;
      cur_v_d      = 1'b1;
      cur_d        = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q  <= '1;
      lbl_q   <= '0;
      live_q  <= '0;
      head_q  <= '0;
      cnt_q   <= '0;
      cur_v_q <= 1'b0;
      cur_q   <= '0;
      sq_v_q  <= 1'b0;
      sq_m_q  <= '0;
    end else begin
      free_q  <= free_d;
      lbl_q   <= lbl_d;
      live_q  <= live_d;
      head_q  <= head_d;
      cnt_q   <= cnt_d;
      cur_v_q <= cur_v_d;
      cur_q   <= cur_d;
      sq_v_q  <= sq_v_d;
      sq_m_q  <= sq_m_d;
    end
  end

  assign cur_valid    = cur_v_q;
  assign cur_label    = cur_q;
  assign squash_valid = sq_v_q;
  assign squash_mask  = sq_m_q;

  // R2: a granted label leaves the pool
  a_r2_grant_leaves_pool: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> !free_q[$past(alloc_label)]);
  // R3: occupancy never exceeds the queue size
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (W+1)'(N));
  // R5: the current label is always an allocated one
  a_r5_cur_allocated: assert property (@(posedge clk) disable iff (!rst_n)
    cur_v_q |-> !free_q[cur_q]);
  // R6: resolutions name live, occupied slots
  a_r6_resolve_live: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (live_q[res_slot] && ({1'b0, from_off} < cnt_q)));
  // R8: a squash report covers at least the resolved label
  a_r8_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    sq_v_q |-> (sq_m_q != '0));
  // R11: no grant in the recovery cycle
  a_r11_recovery_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $past(redir) |-> !alloc_grant);
endmodule

// File: tb/tb_cf_label_tracker.sv
`timescale 1ns/1ps
module tb_cf_label_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_req = 1'b0, res_valid = 1'b0, res_redirect = 1'b0;
  logic [2:0] res_slot = '0;
  logic       alloc_grant, cur_valid, squash_valid;
  logic [2:0] alloc_label, alloc_slot, cur_label;
  logic [7:0] squash_mask;

  always #2 clk = ~clk;

  cf_label_tracker dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_grant(alloc_grant),
    .alloc_label(alloc_label), .alloc_slot(alloc_slot), .cur_valid(cur_valid),
    .cur_label(cur_label), .res_valid(res_valid), .res_redirect(res_redirect),
    .res_slot(res_slot), .squash_valid(squash_valid), .squash_mask(squash_mask)
  );

  int nvec = 0, nfail = 0;
  bit m_free[8];
  int m_lbl[8];
  bit m_live[8];
  int m_head, m_cnt, m_cur;
  bit m_cv, m_sv;
  bit [7:0] m_sm;
  bit cap_g, cap_cv, cap_sv;
  int cap_lbl, cap_slot, cap_cur;
  bit [7:0] cap_sm;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  task automatic step(input bit req, input bit rv, input bit rr, input int rs);
    bit anyf, g, pop;
    int low, tail, offs;
    bit [7:0] mask;
    @(negedge clk);
    alloc_req = req; res_valid = rv; res_redirect = rr; res_slot = 3'(rs);
    #1;
    anyf = 0; low = 0;
    for (int k = 7; k >= 0; k--) if (m_free[k]) begin anyf = 1; low = k; end
    g = req && !(rv && rr) && !m_sv && anyf && (m_cnt < 8);
    tail = (m_head + m_cnt) % 8;
    cap_g = alloc_grant; cap_lbl = alloc_label; cap_slot = alloc_slot;
    cap_cv = cur_valid; cap_cur = cur_label; cap_sv = squash_valid; cap_sm = squash_mask;
    chk("R3 alloc_grant", alloc_grant, g);
    if (g) begin
      chk("R2 alloc_label", alloc_label, low);
      chk("R4 alloc_slot", alloc_slot, tail);
    end
    chk("R5 cur_valid", cur_valid, m_cv);
    if (m_cv) chk("R5 cur_label", cur_label, m_cur);
    chk("R11 squash_valid", squash_valid, m_sv);
    if (m_sv) chk("R8 squash_mask", squash_mask, m_sm);
    // model update for the coming edge
    pop = (m_cnt > 0) && !m_live[m_head];
    offs = (rs - m_head + 8) % 8;
    mask = '0;
    m_sv = rv && rr;
    if (rv && !rr) begin
      m_free[m_lbl[rs]] = 1;
      m_live[rs] = 0;
      if (m_cv && m_cur == m_lbl[rs]) m_cv = 0;
    end
    if (rv && rr) begin
      for (int k = 0; k < 8; k++) begin
        int ok;
        ok = (k - m_head + 8) % 8;
        if (ok >= offs && ok < m_cnt && m_live[k]) begin
          mask[m_lbl[k]] = 1; m_live[k] = 0;
        end
      end
      for (int k = 0; k < 8; k++) if (mask[k]) m_free[k] = 1;
      m_cv = (offs != 0) && m_live[(rs + 7) % 8];
      m_cur = m_lbl[(rs + 7) % 8];
      m_cnt = offs;
    end
    m_sm = mask;
    if (pop) begin
      m_head = (m_head + 1) % 8;
      m_cnt = m_cnt - 1;
    end
    if (g) begin
      m_lbl[tail] = low; m_live[tail] = 1; m_free[low] = 0;
      m_cv = 1; m_cur = low; m_cnt = m_cnt + 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 8; k++) begin m_free[k] = 1; m_lbl[k] = 0; m_live[k] = 0; end
    m_head = 0; m_cnt = 0; m_cv = 0; m_cur = 0; m_sv = 0; m_sm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 cur_valid", cur_valid, 0);
    chk("R1 squash_valid", squash_valid, 0);
    step(1, 0, 0, 0);
    chk("R1 first grant", cap_g, 1);
    chk("R1 first label", cap_lbl, 0);
    chk("R1 first slot", cap_slot, 0);
    for (int i = 1; i < 8; i++) step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R3 no free label", cap_g, 0);
    step(1, 1, 0, 3);
    step(1, 0, 0, 0);
    chk("R3 queue full with dead slot", cap_g, 0);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R6 freed label reused", cap_lbl, 0);
    chk("R7 drained head gives wrapped slot", cap_slot, 0);
    chk("R7 grant after drain", cap_g, 1);
    step(1, 1, 1, 2);
    chk("R11 request dropped on redirect", cap_g, 0);
    step(1, 0, 0, 0);
    chk("R8 squash_valid", cap_sv, 1);
    chk("R8 squash_mask wrapped", cap_sm, 8'hF5);
    chk("R11 recovery stall", cap_g, 0);
    chk("R10 rewound cur_valid", cap_cv, 1);
    chk("R10 rewound cur_label", cap_cur, 1);
    step(1, 0, 0, 0);
    chk("R9 grant after recovery", cap_g, 1);
    chk("R9 label returned", cap_lbl, 0);
    chk("R9 tail at redirect slot", cap_slot, 2);
    step(0, 1, 0, 2);
    step(0, 0, 0, 0);
    chk("R6 cur cleared on own resolve", cap_cv, 0);
    for (int i = 0; i < 6000; i++) begin
      bit rq, rv, rr;
      int rs;
      rq = ($urandom_range(0, 9) < 6);
      rv = 0; rr = 0; rs = 0;
      if (m_cnt > 0 && $urandom_range(0, 9) < 4) begin
        rs = (m_head + $urandom_range(0, m_cnt - 1)) % 8;
        if (m_live[rs]) begin
          rv = 1;
          rr = ($urandom_range(0, 3) == 0);
        end
      end
      step(rq, rv, rr, rs);
    end
    step(0, 0, 0, 0);
    finish_run();
  end
endmodule